// File: doc/BRIEF.md
# Banked General-Purpose I/O Controller

This block gives software control of up to four banks of 32 general-purpose pins over a simple 32-bit register bus. For each bank, a direction register chooses which pins are driven. An output register holds the levels to drive. Two mask registers raise or lower chosen output bits in one write, so software never needs a read-modify-write sequence that another agent could interrupt.

Pin levels come back through a two-flop synchronizer. The value read back is the level seen on the pin, not the value the block drives. Because of this, open-drain and wired-logic schemes work, and a read made just after an output write still shows the old level for a short time.

Each pin can raise an interrupt on a rising edge, a falling edge or both. Paired set and clear registers switch each edge type on or off per pin. A detected edge latches a status bit, and software clears that bit by writing a one to it. Each bank drives its own interrupt line, which is high while any of that bank's status bits is set.

Top module: `banked_gpio`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero), `pin_out` is zero, every `irq` line is low, each direction register reads all ones, and the output, edge-enable and status registers read zero.
- R2: Bank b occupies byte addresses 0x10 + 0x28*b up to 0x10 + 0x28*b + 0x24. Pin n belongs to bank n/32 at bit n%32. The word offsets within a bank are: 0x00 direction, 0x04 output, 0x08 output-set, 0x0C output-clear, 0x10 input level, 0x14 rise-enable set, 0x18 rise-enable clear, 0x1C fall-enable set, 0x20 fall-enable clear, 0x24 status.
- R3: A write to output-set forces to 1 every output bit whose mask bit is 1. A write to output-clear forces those bits to 0. Every other output bit keeps its value. A write to the output register replaces all 32 bits. Reads of output-set and output-clear return the output register.
- R4: A direction bit of 1 makes the pin an input (`pin_oe` bit 0). A direction bit of 0 drives the pin (`pin_oe` bit 1). `pin_out` always carries the output register bits.
- R5: The input-level register returns the synchronized pin level whether the pin is an input or an output. Read data appears on `bus_rdata` in the cycle after `bus_rd_en`. A read request sampled on the same clock edge as a pin change returns the old level. A read sampled two or more edges after that change returns the new level.
- R6: A rising edge sets a status bit only if that pin's rise enable is on. A falling edge sets a status bit only if that pin's fall enable is on. The set registers turn enables on and the clear registers turn them off, one bit per mask bit. Reads at either address return the current enable word.
- R7: A status bit stays set until software writes a 1 to it. Writing a 1 clears only that bit. If an enabled edge arrives in the same cycle as the clear, the bit stays set.
- R8: `irq[b]` is high exactly when some status bit of bank b is set. It rises in the same cycle the status bit becomes visible.
- R9: Reads from addresses that map to no register return zero. Writes to such addresses, and writes to the input-level register, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read strobe |
| pin_in | input | NUM_BANKS*32 | Pin levels sampled from the pads |
| pin_out | output | NUM_BANKS*32 | Output levels |
| pin_oe | output | NUM_BANKS*32 | Output enables, 1 drives the pin |
| irq | output | NUM_BANKS | Per-bank interrupt request |

## Verification
The hardest case to reach is an enabled edge that meets a clear of the same status bit in the same cycle. The edge only becomes visible two clock edges after the pin changes, because it first passes through the synchronizer and the previous-sample flop. The bench changes the pin on a falling clock edge, waits exactly two cycles, and then issues the clear so that the clear lands on the edge where the status bit is set. A clear of the same bit that is mistimed would leave the bit at zero, so a stray clear is caught. The read-lag case is reached the same way: the bench raises a pin level and a read request together and expects the old level back.

// File: rtl/banked_gpio_pkg.sv
package banked_gpio_pkg;
  // Register index inside one bank: word offset / 4
  typedef enum logic [3:0] {
    REG_DIR      = 4'd0,
    REG_OUT      = 4'd1,
    REG_SET      = 4'd2,
    REG_CLR      = 4'd3,
    REG_IN       = 4'd4,
    REG_RISE_SET = 4'd5,
    REG_RISE_CLR = 4'd6,
    REG_FALL_SET = 4'd7,
    REG_FALL_CLR = 4'd8,
    REG_STAT     = 4'd9
  } gpio_reg_e;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import banked_gpio_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned BANK_BASE   = 16,
  parameter int unsigned BANK_STRIDE = 40,
  localparam int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BANK_W-1:0] bank,
  output gpio_reg_e         idx
);
  localparam int unsigned SPAN_END = BANK_BASE + NUM_BANKS * BANK_STRIDE;

  int unsigned addr_u;
  int unsigned off_u;

  always_comb begin
    addr_u = 32'(addr);
    hit    = (addr_u >= BANK_BASE) && (addr_u < SPAN_END);
    off_u  = hit ? (addr_u - BANK_BASE) : 32'd0;
    bank   = BANK_W'(off_u / BANK_STRIDE);
    idx    = gpio_reg_e'(4'((off_u % BANK_STRIDE) >> 2));
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import banked_gpio_pkg::*;
#(
  parameter int unsigned PIN_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  gpio_reg_e        reg_idx,
  input  logic [PIN_W-1:0] wdata,
  output logic [PIN_W-1:0] rd_word,
  input  logic [PIN_W-1:0] pin_in,
  output logic [PIN_W-1:0] pin_out,
  output logic [PIN_W-1:0] pin_oe,
  output logic             irq
);
  logic [PIN_W-1:0] dir_q, out_q, rise_en_q, fall_en_q, stat_q, stat_d;
  logic [SYNC_STAGES-1:0][PIN_W-1:0] sync_q;
  logic [PIN_W-1:0] prev_q, level, rise_hit, fall_hit, w1c;
  logic             irq_q;

  // Pad synchronizer plus previous-sample register for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    level    = sync_q[SYNC_STAGES-1];
    rise_hit = level & ~prev_q & rise_en_q;
    fall_hit = ~level & prev_q & fall_en_q;
    w1c      = (wr_en && reg_idx == REG_STAT) ? wdata : '0;
    stat_d   = (stat_q & ~w1c) | rise_hit | fall_hit;  // edge beats clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= '1;
      out_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      stat_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |stat_d;
      if (wr_en) begin
        unique case (reg_idx)
          REG_DIR:      dir_q     <= wdata;
          REG_OUT:      out_q     <= wdata;
          REG_SET:      out_q     <= out_q | wdata;
          REG_CLR:      out_q     <= out_q & ~wdata;
          REG_RISE_SET: rise_en_q <= rise_en_q | wdata;
          REG_RISE_CLR: rise_en_q <= rise_en_q & ~wdata;
          REG_FALL_SET: fall_en_q <= fall_en_q | wdata;
          REG_FALL_CLR: fall_en_q <= fall_en_q & ~wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_idx)
      REG_DIR:                    rd_word = dir_q;
      REG_OUT, REG_SET, REG_CLR:  rd_word = out_q;
      REG_IN:                     rd_word = level;
      REG_RISE_SET, REG_RISE_CLR: rd_word = rise_en_q;
      REG_FALL_SET, REG_FALL_CLR: rd_word = fall_en_q;
      REG_STAT:                   rd_word = stat_q;
      default:                    rd_word = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq     = irq_q;

  assert_set_drives_ones_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == REG_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));
  assert_clr_drives_zeros_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == REG_CLR) |=> ((out_q & $past(wdata)) == '0));
  assert_set_keeps_others_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == REG_SET) |=> ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));
  assert_oe_follows_dir_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == REG_DIR) |=> (pin_oe == ~$past(wdata)));
  assert_stat_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~($past(rise_en_q) | $past(fall_en_q))) == '0));
  assert_stat_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(stat_q) & ~$past(w1c)) & ~stat_q) == '0));
  assert_irq_matches_stat_R8: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q != '0));
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
  import banked_gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BANK_BASE   = 16,
  parameter int unsigned BANK_STRIDE = 40,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W     = 32,
  localparam int unsigned NPINS      = NUM_BANKS * DATA_W,
  localparam int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NUM_BANKS-1:0] irq
);
  logic              hit;
  logic [BANK_W-1:0] bank_sel;
  gpio_reg_e         reg_idx;
  logic [DATA_W-1:0] rd_words [NUM_BANKS];
  logic [DATA_W-1:0] rdata_q;

  gpio_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
    .BANK_BASE(BANK_BASE), .BANK_STRIDE(BANK_STRIDE)
  ) u_decode (
    .addr(bus_addr), .hit(hit), .bank(bank_sel), .idx(reg_idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_wr_en && hit && (bank_sel == BANK_W'(b));
    gpio_bank #(.PIN_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bank_wr),
      .reg_idx (reg_idx),
      .wdata   (bus_wdata),
      .rd_word (rd_words[b]),
      .pin_in  (pin_in[b*DATA_W +: DATA_W]),
      .pin_out (pin_out[b*DATA_W +: DATA_W]),
      .pin_oe  (pin_oe[b*DATA_W +: DATA_W]),
      .irq     (irq[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                   rdata_q <= '0;
    else if (bus_rd_en && hit) rdata_q <= rd_words[bank_sel];
    else                       rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;

  assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && !hit) |=> (bus_rdata == '0));
endmodule

// File: tb/banked_gpio_tb.sv
module banked_gpio_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out, pin_oe;
  logic [3:0]   irq;

  int n_checks = 0, n_fails = 0, cyc = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  banked_gpio u_dut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h14, 32'hF0F0_0000, 32'h0,          4'd3}, // R3 bank0 output write
    '{1'b0, 8'h14, 32'h0,         32'hF0F0_0000, 4'd3},
    '{1'b1, 8'h18, 32'h0000_00FF, 32'h0,          4'd3}, // R3 set mask
    '{1'b0, 8'h14, 32'h0,         32'hF0F0_00FF, 4'd3},
    '{1'b1, 8'h1C, 32'hF000_000F, 32'h0,          4'd3}, // R3 clear mask
    '{1'b0, 8'h18, 32'h0,         32'h00F0_00F0, 4'd3}, // set reg reads output
    '{1'b0, 8'h1C, 32'h0,         32'h00F0_00F0, 4'd3}, // clear reg reads output
    '{1'b1, 8'h38, 32'h0000_FFFF, 32'h0,          4'd2}, // R2 bank1 direction
    '{1'b0, 8'h38, 32'h0,         32'h0000_FFFF, 4'd2},
    '{1'b1, 8'h64, 32'hA5A5_A5A5, 32'h0,          4'd2}, // R2 bank2 output
    '{1'b0, 8'h64, 32'h0,         32'hA5A5_A5A5, 4'd2},
    '{1'b0, 8'h14, 32'h0,         32'h00F0_00F0, 4'd2}, // bank0 untouched
    '{1'b1, 8'h9C, 32'h8000_0001, 32'h0,          4'd6}, // R6 bank3 rise set
    '{1'b0, 8'hA0, 32'h0,         32'h8000_0001, 4'd6},
    '{1'b1, 8'hA0, 32'h0000_0001, 32'h0,          4'd6}, // R6 rise clear
    '{1'b0, 8'h9C, 32'h0,         32'h8000_0000, 4'd6},
    '{1'b1, 8'hB0, 32'h1234_5678, 32'h0,          4'd9}, // R9 past last bank
    '{1'b0, 8'hB0, 32'h0,         32'h0,          4'd9},
    '{1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0,          4'd9}, // R9 input reg write ignored
    '{1'b0, 8'h20, 32'h0,         32'h0,          4'd9}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 irq", 128'(irq), '0);
    bus_read(8'h10, rd); check("R1 dir", 128'(rd), 128'hFFFF_FFFF);
    bus_read(8'h34, rd); check("R1 stat", 128'(rd), '0);
    bus_read(8'h24, rd); check("R1 rise enable", 128'(rd), '0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rd);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), 128'(rd), 128'(VECS[i].exp));
      end
    end
    bus_read(8'h00, rd); check("R9 below base", 128'(rd), '0);

    // R4 direction and output enables
    check("R4 bank0 all input", 128'(pin_oe[31:0]), '0);
    check("R4 bank1 oe", 128'(pin_oe[63:32]), 128'hFFFF_0000);
    bus_write(8'h10, 32'hFFFF_0000);
    check("R4 bank0 oe", 128'(pin_oe[31:0]), 128'h0000_FFFF);
    check("R4 bank0 pin_out", 128'(pin_out[31:0]), 128'h00F0_00F0);

    // R5 input lag and wired read-back on pin 100 (bank3 bit4), driven low
    bus_write(8'h88, 32'h0);
    bus_write(8'h8C, 32'h0);
    @(negedge clk);
    pin_in[100] = 1'b1; bus_rd_en = 1'b1; bus_addr = 8'h98;
    @(negedge clk);
    bus_rd_en = 1'b0;
    check("R5 read lags pin", 128'(bus_rdata), '0);
    settle();
    bus_read(8'h98, rd); check("R5 pin level despite driving 0", 128'(rd), 128'h10);
    check("R5 bank3 irq quiet", 128'(irq), '0);

    // Edge interrupts: bank0 rise on bit0, fall on bit1
    bus_write(8'h24, 32'h1);
    bus_write(8'h2C, 32'h2);
    pin_in[0] = 1'b1; settle();
    bus_read(8'h34, rd); check("R7 rise latched", 128'(rd), 128'h1);
    check("R8 irq bank0", 128'(irq), 128'h1);
    pin_in[1] = 1'b1; settle();
    bus_read(8'h34, rd); check("R6 rise not enabled bit1", 128'(rd), 128'h1);
    pin_in[1] = 1'b0; settle();
    bus_read(8'h34, rd); check("R6 fall enabled bit1", 128'(rd), 128'h3);
    bus_write(8'h34, 32'h1);
    bus_read(8'h34, rd); check("R7 w1c one bit", 128'(rd), 128'h2);
    check("R8 irq still high", 128'(irq), 128'h1);
    bus_write(8'h34, 32'h2);
    bus_read(8'h34, rd); check("R7 all cleared", 128'(rd), '0);
    check("R8 irq low", 128'(irq), '0);
    pin_in[0] = 1'b0; settle();
    bus_read(8'h34, rd); check("R6 fall not enabled bit0", 128'(rd), '0);

    // R7 edge and clear in the same cycle
    @(negedge clk);
    pin_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 8'h34; bus_wdata = 32'h1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    bus_read(8'h34, rd); check("R7 edge beats clear", 128'(rd), 128'h1);
    bus_write(8'h34, 32'h1);

    // R8/R2 pin 127 maps to bank3 bit31
    pin_in[127] = 1'b1; settle();
    check("R8 irq bank3 only", 128'(irq), 128'h8);
    bus_read(8'hAC, rd); check("R2 bank3 stat bit31", 128'(rd), 128'h8000_0000);

    summary();
    $finish;
  end
endmodule